// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache

This block sits between a load/store unit and a plain word-wide memory port. It holds 4 KB of data in two ways of 128 lines each, with 16-byte lines of four 32-bit words. Tags and data are held in synchronous RAM arrays. The valid, dirty and replacement state of every set sits in a separate register array, so that state can be read and updated in the same cycle as the lookup.

The set index and the word select come from the untranslated address bits. The physical tag is presented alongside them and is captured with the request. In the cycle after acceptance, the RAM outputs are compared against that tag. Reads that miss fetch the whole line into a chosen way. Every write goes through to memory, and a write that misses leaves the cache contents untouched.

Top module: `dcache2w`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1 and `rsp_valid` and `mem_req` are 0, so the first read of any address misses.
- R2: A read whose physical tag matches a valid way in the indexed set raises `rsp_valid` in the cycle after acceptance, returns the stored word and makes no memory request.
- R3: A read miss issues four memory reads at the line base plus byte offsets 0, 4, 8 and 12, in that order. It then returns the requested word with `rsp_valid` one cycle after the fourth acknowledge.
- R4: A hit needs both an equal physical tag and a valid way. The same untranslated index with another physical tag misses.
- R5: On a miss, an invalid way of the set is filled before a valid one, so two lines with different tags can be resident in one set at the same time.
- R6: Any hit marks the way that was not accessed as least recently used. A completed refill marks the way that was not filled. A miss in a full set replaces the least recently used way.
- R7: A write hit stores the word into the hitting way and sets that way's dirty bit. It also issues one memory write at the physical address `{ptag, index, word, 2'b00}` and raises `rsp_valid` on the write acknowledge. A refill of a way clears its dirty bit.
- R8: A write miss issues one memory write and allocates no line, so a later read of that address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when `req_ready` is 1 |
| req_we | input | 1 | 1 = store, 0 = load |
| req_vword | input | 9 | Untranslated word address: set index in bits 8:2, word within line in bits 1:0 |
| req_ptag | input | 21 | Physical tag (physical address bits 31:11) |
| req_wdata | input | 32 | Store data |
| req_ready | output | 1 | Cache idle and able to accept |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Load data, valid with `rsp_valid` on loads |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| mem_rdata | input | 32 | Memory read data |

## Verification
A write hit does three things in its lookup cycle: it updates the data word, it sets the dirty and replacement state, and it starts the write-through. The bench provokes this by writing to a resident line. It then judges three results: exactly one memory write with the right address and data, a following read that returns the new word with no memory traffic, and a replacement order that shows the write counted as a use. Replacement after hits and refills in one set is judged by the order in which lines miss again.

// File: rtl/dcache2w.sv
module dcache2w #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CAPACITY   = 4096,
  parameter int LINE_BYTES = 16,
  localparam int WORD_BYTES = DATA_W / 8,
  localparam int WPL        = LINE_BYTES / WORD_BYTES,
  localparam int SETS       = CAPACITY / (2 * LINE_BYTES),
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int IDX_W      = $clog2(SETS),
  localparam int WSEL_W     = $clog2(WPL),
  localparam int BSEL_W     = $clog2(WORD_BYTES),
  localparam int TAG_W      = ADDR_W - IDX_W - OFF_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_we,
  input  logic [IDX_W+WSEL_W-1:0]   req_vword,
  input  logic [TAG_W-1:0]          req_ptag,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic                      req_ready,
  output logic                      rsp_valid,
  output logic [DATA_W-1:0]         rsp_rdata,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [DATA_W-1:0]         mem_wdata,
  input  logic                      mem_ack,
  input  logic [DATA_W-1:0]         mem_rdata
);
  localparam logic [WSEL_W-1:0] LAST = WSEL_W'(WPL - 1);

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_FILL, S_RESP, S_WMEM} st_t;
  st_t st;

  logic [TAG_W-1:0]  tag_ram  [2][SETS];
  logic [DATA_W-1:0] data_ram [2][SETS*WPL];
  logic [TAG_W-1:0]  tag_q0, tag_q1;
  logic [DATA_W-1:0] dat_q0, dat_q1;

  logic [SETS-1:0]   valid0, valid1, dirty0, dirty1, lru;
  logic [IDX_W-1:0]  idx_q;
  logic [WSEL_W-1:0] wsel_q, cnt;
  logic [TAG_W-1:0]  ptag_q;
  logic [DATA_W-1:0] wdata_q, fill_word;
  logic              we_q, vict;

  wire accept  = req_valid && st == S_IDLE;
  wire hit0    = valid0[idx_q] && tag_q0 == ptag_q;
  wire hit1    = valid1[idx_q] && tag_q1 == ptag_q;
  wire hit     = hit0 || hit1;
  wire wr_hit  = st == S_LOOK && we_q && hit;
  wire fill_wr = st == S_FILL && mem_ack;

  always_ff @(posedge clk) begin
    if (accept) begin
      tag_q0 <= tag_ram[0][req_vword[IDX_W+WSEL_W-1:WSEL_W]];
      tag_q1 <= tag_ram[1][req_vword[IDX_W+WSEL_W-1:WSEL_W]];
      dat_q0 <= data_ram[0][req_vword];
      dat_q1 <= data_ram[1][req_vword];
    end
    if (wr_hit) data_ram[hit1][{idx_q, wsel_q}] <= wdata_q;
    if (fill_wr) data_ram[vict][{idx_q, cnt}] <= mem_rdata;
    if (fill_wr && cnt == LAST) tag_ram[vict][idx_q] <= ptag_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      valid0 <= '0; valid1 <= '0; dirty0 <= '0; dirty1 <= '0; lru <= '0;
      idx_q <= '0; wsel_q <= '0; ptag_q <= '0; wdata_q <= '0; we_q <= 1'b0;
      cnt <= '0; vict <= 1'b0; fill_word <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          idx_q   <= req_vword[IDX_W+WSEL_W-1:WSEL_W];
          wsel_q  <= req_vword[WSEL_W-1:0];
          ptag_q  <= req_ptag;
          wdata_q <= req_wdata;
          we_q    <= req_we;
          st      <= S_LOOK;
        end
        S_LOOK: begin
          if (hit) lru[idx_q] <= hit0;
          if (we_q) begin
            if (hit0) dirty0[idx_q] <= 1'b1;
            if (hit1) dirty1[idx_q] <= 1'b1;
            st <= S_WMEM;
          end else if (hit) begin
            st <= S_IDLE;
          end else begin
            vict <= !valid0[idx_q] ? 1'b0 : (!valid1[idx_q] ? 1'b1 : lru[idx_q]);
            cnt  <= '0;
            st   <= S_FILL;
          end
        end
        S_FILL: if (mem_ack) begin
          if (cnt == wsel_q) fill_word <= mem_rdata;
          if (cnt == LAST) begin
            if (vict) begin valid1[idx_q] <= 1'b1; dirty1[idx_q] <= 1'b0; end
            else      begin valid0[idx_q] <= 1'b1; dirty0[idx_q] <= 1'b0; end
            lru[idx_q] <= ~vict;
            st <= S_RESP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RESP: st <= S_IDLE;
        S_WMEM: if (mem_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = st == S_IDLE;
  assign rsp_valid = (st == S_LOOK && !we_q && hit) || st == S_RESP || (st == S_WMEM && mem_ack);
  assign rsp_rdata = st == S_RESP ? fill_word : (hit1 ? dat_q1 : dat_q0);
  assign mem_req   = st == S_FILL || st == S_WMEM;
  assign mem_we    = st == S_WMEM;
  assign mem_addr  = {ptag_q, idx_q, (st == S_WMEM ? wsel_q : cnt), {BSEL_W{1'b0}}};
  assign mem_wdata = wdata_q;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req && !rsp_valid);

  p_hit_no_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOOK && !we_q && hit) |=> !mem_req && req_ready);

  p_fill_starts_at_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOOK && !we_q && !hit) |=> mem_req && !mem_we && mem_addr[OFF_W-1:BSEL_W] == '0);

  p_fill_ascending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FILL && mem_ack && cnt != LAST) |=>
      mem_req && mem_addr[OFF_W-1:BSEL_W] == $past(mem_addr[OFF_W-1:BSEL_W]) + 1'b1);

  p_fill_way0_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FILL && mem_ack && cnt == LAST && !vict) |=> valid0[idx_q] && !dirty0[idx_q] && lru[idx_q]);

  p_lru_after_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOOK && hit0) |=> lru[$past(idx_q)]);

  p_write_hit_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOOK && we_q && hit1) |=> dirty1[$past(idx_q)] && mem_we && mem_req);

  p_write_miss_no_alloc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOOK && we_q && !hit) |=> $stable(valid0) && $stable(valid1));
endmodule

// File: tb/sim_dcache2w.sv
`timescale 1ns/1ps
module sim_dcache2w;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [8:0]  req_vword = '0;
  logic [20:0] req_ptag = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, mem_req, mem_we;
  logic [31:0] rsp_rdata, mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2 clk = ~clk;

  dcache2w u0 (.clk, .rst_n, .req_valid, .req_we, .req_vword, .req_ptag, .req_wdata,
               .req_ready, .rsp_valid, .rsp_rdata, .mem_req, .mem_we, .mem_addr,
               .mem_wdata, .mem_ack, .mem_rdata);

  int compared = 0, mismatched = 0;
  int nrd = 0, nwr = 0, dly = 0;
  logic [31:0] rd_log[$];
  logic [31:0] wr_addr_last, wr_data_last;
  logic [31:0] wmem [logic [31:0]];

  function automatic logic [31:0] mval(logic [31:0] a);
    if (wmem.exists(a)) return wmem[a];
    return (a * 32'h9E37_79B9) ^ 32'h1234_5678;
  endfunction

  function automatic logic [31:0] pa(logic [20:0] t, logic [8:0] vw);
    return {t, vw, 2'b00};
  endfunction

  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      if (dly == 2) begin
        dly <= 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          wmem[mem_addr] = mem_wdata;
          wr_addr_last <= mem_addr; wr_data_last <= mem_wdata; nwr <= nwr + 1;
        end else begin
          mem_rdata <= mval(mem_addr);
          rd_log.push_back(mem_addr); nrd <= nrd + 1;
        end
      end else dly <= dly + 1;
    end else mem_ack <= 1'b0;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [8:0] vw, input logic [20:0] t,
                        input logic [31:0] wd, output logic [31:0] rd, output int lat,
                        output int drd, output int dwr);
    int r0, w0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    r0 = nrd; w0 = nwr;
    req_valid = 1'b1; req_we = we; req_vword = vw; req_ptag = t; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 200) begin @(negedge clk); lat++; end
    rd = rsp_rdata;
    @(negedge clk);
    drd = nrd - r0; dwr = nwr - w0;
  endtask

  task automatic t_reset;
    chk("R1 ready", {31'b0, req_ready}, 32'd1);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
  endtask

  task automatic t_miss_refill;
    logic [31:0] rd; int lat, dr, dw, base;
    base = rd_log.size();
    access(1'b0, {7'd3, 2'd2}, 21'h0A, 0, rd, lat, dr, dw);
    chk("R1 first read misses", dr, 4);
    chk("R3 refill data", rd, mval(pa(21'h0A, {7'd3, 2'd2})));
    chk("R3 no writes", dw, 0);
    for (int k = 0; k < 4; k++)
      chk("R3 refill order", rd_log[base + k], pa(21'h0A, {7'd3, 2'(k)}));
  endtask

  task automatic t_hit;
    logic [31:0] rd; int lat, dr, dw;
    access(1'b0, {7'd3, 2'd1}, 21'h0A, 0, rd, lat, dr, dw);
    chk("R2 hit data", rd, mval(pa(21'h0A, {7'd3, 2'd1})));
    chk("R2 hit no memory", dr, 0);
    chk("R2 hit latency", lat, 1);
  endtask

  task automatic t_ptag;
    logic [31:0] rd; int lat, dr, dw;
    access(1'b0, {7'd3, 2'd1}, 21'h0B, 0, rd, lat, dr, dw);
    chk("R4 other ptag misses", dr, 4);
    chk("R4 data", rd, mval(pa(21'h0B, {7'd3, 2'd1})));
    access(1'b0, {7'd3, 2'd3}, 21'h0A, 0, rd, lat, dr, dw);
    chk("R5 first line kept", dr, 0);
    access(1'b0, {7'd3, 2'd0}, 21'h0B, 0, rd, lat, dr, dw);
    chk("R5 second line resident", dr, 0);
    chk("R5 data", rd, mval(pa(21'h0B, {7'd3, 2'd0})));
  endtask

  task automatic t_lru;
    logic [31:0] rd; int lat, dr, dw;
    access(1'b0, {7'd9, 2'd0}, 21'h11, 0, rd, lat, dr, dw);
    access(1'b0, {7'd9, 2'd0}, 21'h22, 0, rd, lat, dr, dw);
    access(1'b0, {7'd9, 2'd1}, 21'h11, 0, rd, lat, dr, dw);
    chk("R6 hit before eviction", dr, 0);
    access(1'b0, {7'd9, 2'd2}, 21'h33, 0, rd, lat, dr, dw);
    chk("R6 third tag misses", dr, 4);
    access(1'b0, {7'd9, 2'd0}, 21'h11, 0, rd, lat, dr, dw);
    chk("R6 recently used line kept", dr, 0);
    access(1'b0, {7'd9, 2'd0}, 21'h22, 0, rd, lat, dr, dw);
    chk("R6 LRU line evicted", dr, 4);
  endtask

  task automatic t_write_hit;
    logic [31:0] rd; int lat, dr, dw;
    access(1'b1, {7'd3, 2'd0}, 21'h0A, 32'hCAFE_0001, rd, lat, dr, dw);
    chk("R7 one write", dw, 1);
    chk("R7 no reads", dr, 0);
    chk("R7 write address", wr_addr_last, pa(21'h0A, {7'd3, 2'd0}));
    chk("R7 write data", wr_data_last, 32'hCAFE_0001);
    access(1'b0, {7'd3, 2'd0}, 21'h0A, 0, rd, lat, dr, dw);
    chk("R7 cached word updated", rd, 32'hCAFE_0001);
    chk("R7 read back hits", dr, 0);
    // write to 0B counts as a use: 0A becomes LRU and is evicted by 0C
    access(1'b1, {7'd3, 2'd2}, 21'h0B, 32'hBEEF_0002, rd, lat, dr, dw);
    access(1'b0, {7'd3, 2'd0}, 21'h0C, 0, rd, lat, dr, dw);
    access(1'b0, {7'd3, 2'd2}, 21'h0B, 0, rd, lat, dr, dw);
    chk("R7 written line survives", dr, 0);
    chk("R7 written word", rd, 32'hBEEF_0002);
  endtask

  task automatic t_write_miss;
    logic [31:0] rd; int lat, dr, dw;
    access(1'b1, {7'd20, 2'd1}, 21'h44, 32'h5A5A_7777, rd, lat, dr, dw);
    chk("R8 one write", dw, 1);
    chk("R8 no refill", dr, 0);
    chk("R8 write address", wr_addr_last, pa(21'h44, {7'd20, 2'd1}));
    access(1'b0, {7'd20, 2'd1}, 21'h44, 0, rd, lat, dr, dw);
    chk("R8 not allocated", dr, 4);
    chk("R8 data from memory", rd, 32'h5A5A_7777);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++; compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_miss_refill();
    t_hit();
    t_ptag();
    t_lru();
    t_write_hit();
    t_write_miss();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule